// File: doc/BRIEF.md
# Banked Doorbell Mailbox

This unit lets one processor signal another through three independent doorbell banks. The banks are low-priority non-secure, high-priority non-secure and secure. Each bank holds a 32-bit pending word. Every bit of the word can stand for its own event. A writer raises bits through a write-one-to-set register and lowers them through a write-one-to-clear register. Because both registers only act on the bits written as one, several writers can ring different bits without a read-modify-write.

The receiver gets one interrupt line per bank. Each line is the OR of that bank's 32 pending bits, taken through a register. The receiver finds out which event fired by reading the bank's status word.

Access goes through a small register port. A request is accepted when `req_valid` and `req_ready` are both high. Every accepted request, read or write, produces exactly one response beat. A response waits on `rsp_valid` until `rsp_ready` is high, and its data does not change while it waits. A new request is accepted only when no response is pending, or when the pending response is taken in the same cycle. The port therefore holds the master back for as long as the response is stalled.

Top module: `doorbell_unit`

## Requirements
- R1: After reset, every pending word is zero, every interrupt line is low, `rsp_valid` is low and `req_ready` is high.
- R2: A write to a bank's set register (window offset 0x08) sets each status bit written as 1. Bits written as 0 keep their value.
- R3: A write to a bank's clear register (window offset 0x10) clears each status bit written as 1. Bits written as 0 keep their value.
- R4: Separate set writes to different bits of one bank accumulate. For example, 0x800 followed by 0x400 leaves 0xC00 pending.
- R5: Each bank's interrupt line equals the OR of its pending word one clock after the word changes. The word changes on the clock edge that accepts the write, and the line follows on the next edge.
- R6: The banks sit in 32-byte windows at base addresses 0x000 (low priority), 0x020 (high priority) and 0x200 (secure). A read of window offset 0x00 returns that bank's status word. A write to one bank leaves the other banks unchanged.
- R7: While `req_secure` is low, an access to the secure bank reads zero and its writes leave the secure word unchanged. Accesses to the non-secure banks do not depend on `req_secure`.
- R8: Reads of the set and clear registers, of unused offsets and of unmapped addresses return zero. Writes to a status register or to unmapped addresses change no pending word.
- R9: Each accepted request yields one response, in order, with data equal to the read result at acceptance time (zero for writes). A stalled response keeps `rsp_valid` high and its data stable until `rsp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (12) | Byte address |
| req_wdata | input | DATA_W (32) | Write data |
| req_secure | input | 1 | Access carries the secure attribute |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Master takes the response |
| rsp_rdata | output | DATA_W (32) | Read data (zero for writes) |
| irq_o | output | NUM_CH (3) | Per-bank interrupt: bit 0 low priority, bit 1 high priority, bit 2 secure |

## Verification
The bench builds the unit with its defaults: 32-bit words, 12-bit addresses, and window bases 0x000, 0x020 and 0x200.

Because the secure base is 0x200, decoding has to use the upper address bits. That makes it possible to check that addresses such as 0x100 and 0x220 alias to no bank. The full 32-bit word allows patterns at both ends of the word and the 0x800/0x400 doorbell pair.

Three response stall patterns are applied while requests are issued back to back. This exercises holding responses and back-pressuring requests.

// File: rtl/db_pkg.sv
package db_pkg;
  // Window geometry: each bank owns 2**DB_WIN_W bytes.
  localparam int DB_WIN_W   = 5;
  localparam int DB_NUM_CH  = 3;
  // Register offsets inside one bank window.
  localparam int DB_OFS_STATUS = 'h00;
  localparam int DB_OFS_SET    = 'h08;
  localparam int DB_OFS_CLR    = 'h10;

  typedef enum logic [1:0] {
    CH_LOW  = 2'd0,
    CH_HIGH = 2'd1,
    CH_SEC  = 2'd2
  } db_chan_e;
endpackage

// File: rtl/db_channel.sv
module db_channel #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_mask,
  input  logic [DATA_W-1:0] clr_mask,
  output logic [DATA_W-1:0] status_q,
  output logic              irq_q
);
  logic [DATA_W-1:0] status_d;

  // Set dominates a clear of the same bit so no doorbell is dropped.
  always_comb status_d = (status_q & ~clr_mask) | set_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= |status_q;
    end
  end

  // R2
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask != '0) |=> ((status_q & $past(set_mask)) == $past(set_mask)));

  // R3
  clear_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_mask & ~set_mask) != '0) |=> ((status_q & $past(clr_mask & ~set_mask)) == '0));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask == '0 && clr_mask == '0) |=> $stable(status_q));
endmodule

// File: rtl/db_decode.sv
module db_decode
  import db_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter int NUM_CH  = 3,
  parameter int SEC_IDX = 2,
  parameter logic [NUM_CH-1:0][ADDR_W-1:0] BASES = '0
) (
  input  logic                           accept,
  input  logic                           write,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  input  logic                           secure,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  status,
  output logic [NUM_CH-1:0][DATA_W-1:0]  set_mask,
  output logic [NUM_CH-1:0][DATA_W-1:0]  clr_mask,
  output logic [DATA_W-1:0]              rd_data
);
  localparam int HI_W = ADDR_W - DB_WIN_W;

  logic [DB_WIN_W-1:0] ofs;
  logic [NUM_CH-1:0]   sel;
  logic [NUM_CH-1:0][DATA_W-1:0] rd_part;

  assign ofs = addr[DB_WIN_W-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
    logic hit;
    logic allowed;
    assign hit     = (addr[ADDR_W-1:DB_WIN_W] == BASES[c][ADDR_W-1:DB_WIN_W]);
    assign allowed = (c != SEC_IDX) || secure;
    assign sel[c]  = hit && allowed;

    always_comb begin
      set_mask[c] = '0;
      clr_mask[c] = '0;
      if (accept && write && sel[c]) begin
        if (ofs == DB_WIN_W'(DB_OFS_SET)) set_mask[c] = wdata;
        if (ofs == DB_WIN_W'(DB_OFS_CLR)) clr_mask[c] = wdata;
      end
    end

    assign rd_part[c] = (sel[c] && !write && ofs == DB_WIN_W'(DB_OFS_STATUS))
                        ? status[c] : '0;
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NUM_CH; c++) rd_data = rd_data | rd_part[c];
  end

  // R6
  one_bank_chk: assert property (@(posedge accept) 1'b1 |-> $onehot0(sel))
    else $error("two bank windows matched one address");

  logic unused_hi;
  assign unused_hi = (HI_W < 1);
endmodule

// File: rtl/db_reg_port.sv
module db_reg_port #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [DATA_W-1:0] rd_data,
  output logic              accept
);
  logic              pend_q;
  logic [DATA_W-1:0] data_q;

  assign req_ready = !pend_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign rsp_valid = pend_q;
  assign rsp_rdata = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      data_q <= '0;
    end else if (accept) begin
      pend_q <= 1'b1;
      data_q <= rd_data;
    end else if (rsp_ready) begin
      pend_q <= 1'b0;
    end
  end

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R9
  no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit
  import db_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int NUM_CH = DB_NUM_CH,
  parameter logic [NUM_CH-1:0][ADDR_W-1:0] BASES = {12'h200, 12'h020, 12'h000}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_secure,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int SEC_IDX = int'(CH_SEC);

  logic                          accept;
  logic [DATA_W-1:0]             rd_data;
  logic [NUM_CH-1:0][DATA_W-1:0] set_mask;
  logic [NUM_CH-1:0][DATA_W-1:0] clr_mask;
  logic [NUM_CH-1:0][DATA_W-1:0] status;

  db_reg_port #(.DATA_W(DATA_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .rd_data   (rd_data),
    .accept    (accept)
  );

  db_decode #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .NUM_CH  (NUM_CH),
    .SEC_IDX (SEC_IDX),
    .BASES   (BASES)
  ) u_dec (
    .accept   (accept),
    .write    (req_write),
    .addr     (req_addr),
    .wdata    (req_wdata),
    .secure   (req_secure),
    .status   (status),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .rd_data  (rd_data)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    db_channel #(.DATA_W(DATA_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_mask (set_mask[c]),
      .clr_mask (clr_mask[c]),
      .status_q (status[c]),
      .irq_q    (irq_o[c])
    );

    // R5
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[c] == (|$past(status[c])));
  end

  // R7
  secure_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && !req_secure &&
     req_addr[ADDR_W-1:DB_WIN_W] == BASES[SEC_IDX][ADDR_W-1:DB_WIN_W])
    |=> $stable(status[SEC_IDX]));
endmodule

// File: tb/sim_doorbell_unit.sv
`timescale 1ns/1ps
module sim_doorbell_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_secure = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [2:0]  irq_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int stall_mode = 0;
  logic [31:0] model [3];
  logic [31:0] exp_q [$];
  string       tag_q [$];
  bit          done = 1'b0;

  always #5 clk = ~clk;

  doorbell_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_secure(req_secure), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bank index from the address map, -1 when no bank is reachable.
  function automatic int bank_of(input logic [11:0] a, input logic sec);
    logic [11:0] b;
    b = a & 12'hFE0;
    if (b == 12'h000) return 0;
    if (b == 12'h020) return 1;
    if (b == 12'h200) return sec ? 2 : -1;
    return -1;
  endfunction

  // Driver: issue one request, push the expected response, update the model.
  task automatic bus(input logic wr, input logic [11:0] a, input logic [31:0] d,
                     input logic sec, input string tag);
    int ch;
    logic [4:0] ofs;
    logic [31:0] exp;
    ch  = bank_of(a, sec);
    ofs = a[4:0];
    exp = 32'h0;
    if (!wr && ch >= 0 && ofs == 5'h00) exp = model[ch];
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_secure = sec;
    while (!req_ready) @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    if (wr && ch >= 0) begin
      if (ofs == 5'h08) model[ch] = model[ch] | d;
      if (ofs == 5'h10) model[ch] = model[ch] & ~d;
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Response stall pattern, changed just after each edge.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    case (stall_mode)
      0: rsp_ready = 1'b1;
      1: rsp_ready = (cyc % 3) != 0;
      default: rsp_ready = (cyc % 5) > 2;
    endcase
  end

  // Monitor: compare responses against the scoreboard.
  logic        hold_pend = 1'b0;
  logic [31:0] hold_data = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        check("R9 stalled valid", {31'h0, rsp_valid}, 32'h1);
        check("R9 stalled data", rsp_rdata, hold_data);
      end
      hold_pend = rsp_valid && !rsp_ready;
      hold_data = rsp_rdata;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check("R9 extra response", 32'h1, 32'h0);
        end else begin
          check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) model[i] = 32'h0;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check("R1 irq", {29'h0, irq_o}, 32'h0);
    check("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    check("R1 req_ready", {31'h0, req_ready}, 32'h1);
    rst_n = 1'b1;
    bus(0, 12'h000, 0, 1, "R1 status low");
    bus(0, 12'h020, 0, 1, "R1 status high");
    bus(0, 12'h200, 0, 1, "R1 status secure");
    drain();

    // R5 interrupt timing: word changes at the accepting edge, line one edge later
    bus(1, 12'h008, 32'h1, 0, "R5 write response");
    check("R5 irq not yet", {31'h0, irq_o[0]}, 32'h0);
    @(posedge clk); #1;
    check("R5 irq raised", {31'h0, irq_o[0]}, 32'h1);
    drain();

    stall_mode = 1;
    // R4 independent doorbells accumulate
    bus(1, 12'h028, 32'h800, 0, "R4 set a");
    bus(1, 12'h028, 32'h400, 1, "R4 set b");
    bus(0, 12'h020, 0, 0, "R4 pair pending");
    // R2 zero bits have no effect
    bus(1, 12'h008, 32'h0000_00F0, 0, "R2 set write");
    bus(0, 12'h000, 0, 0, "R2 status after set");
    bus(1, 12'h008, 32'h8000_0000, 0, "R2 msb set");
    bus(0, 12'h000, 0, 0, "R2 msb status");
    // R3 clear acts only on ones
    bus(1, 12'h010, 32'h0000_0011, 0, "R3 clear write");
    bus(0, 12'h000, 0, 0, "R3 status after clear");
    drain();
    check("R5 irq follows words", {29'h0, irq_o}, 32'h3);

    stall_mode = 2;
    // R6 secure bank with attribute, banks independent
    bus(1, 12'h208, 32'hA5A5_0000, 1, "R6 secure set");
    bus(0, 12'h020, 0, 0, "R6 high bank untouched");
    bus(0, 12'h200, 0, 1, "R6 secure status");
    // R7 without the secure attribute
    bus(0, 12'h200, 0, 0, "R7 nonsecure read zero");
    bus(1, 12'h208, 32'h0000_0001, 0, "R7 nonsecure set");
    bus(1, 12'h210, 32'hFFFF_FFFF, 0, "R7 nonsecure clear");
    bus(0, 12'h200, 0, 1, "R7 secure word kept");
    bus(0, 12'h000, 0, 0, "R7 low bank any attribute");
    // R8 write-only reads, status writes, unmapped space
    bus(0, 12'h028, 0, 1, "R8 read set reg");
    bus(0, 12'h030, 0, 1, "R8 read clear reg");
    bus(0, 12'h004, 0, 1, "R8 read unused offset");
    bus(1, 12'h020, 32'hFFFF_FFFF, 1, "R8 write status reg");
    bus(1, 12'h108, 32'hFFFF_FFFF, 1, "R8 write unmapped");
    bus(1, 12'h228, 32'h0000_FFFF, 1, "R8 write alias gap");
    bus(0, 12'h100, 0, 1, "R8 read unmapped");
    bus(0, 12'h020, 0, 1, "R8 high bank unchanged");
    bus(0, 12'h000, 0, 1, "R8 low bank unchanged");
    bus(0, 12'h200, 0, 1, "R8 secure bank unchanged");
    drain();

    stall_mode = 0;
    // R3 clear low bank completely, line drops
    bus(1, 12'h010, 32'hFFFF_FFFF, 0, "R3 clear all");
    bus(0, 12'h000, 0, 0, "R3 low bank empty");
    drain();
    check("R5 irq final", {29'h0, irq_o},
          {29'h0, model[2] != 0, model[1] != 0, model[0] != 0});
    check("R9 queue empty", exp_q.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule